// File: doc/BRIEF.md
# Memory Type Range Resolver

This block answers one question for a cache controller or page-walk unit: which memory type governs a physical address range `[start, end)`. It holds three kinds of configuration. The first is a table of 88 fixed-granule types that covers the lowest 1 MiB. The second is a bank of variable base/mask range registers. The third is a control word with the default type, two enable bits, a flag that says the fixed table exists, and an optional upper-memory limit. Below that limit, memory above 4 GiB is forced to write-back.

A request is offered with a valid/ready handshake. When the answer needs no range scan, the block returns it in the first cycle after acceptance. This covers the disabled unit, a fixed-table hit and the variable ranges being switched off. Otherwise the block visits one variable range per clock. It merges overlapping matches by precedence and stops at once on a partial-coverage error or an uncacheable outcome. The result is an 8-bit code, presented with a one-cycle `done` pulse.

Top module: `mem_type_resolver`

## Requirements
- R1: After reset, `req_ready` is 1 and `done` is 0.
- R2: Until the control word has been written once, every request returns 0xFF.
- R3: When both enable bits (`ctl_enable[1:0]`) are 0, every request returns 0xFF.
- R4: When the fixed table exists and start < 0x100000, the result is the table entry picked by start alone. The index is start>>16 below 0x80000. It is 8+((start-0x80000)>>14) below 0xC0000. Otherwise it is 24+((start-0xC0000)>>12).
- R5: When `ctl_enable[1]` (variable-range enable) is 0 and R4 does not apply, the result is the default type.
- R6: A variable range with bit 11 of its mask clear takes no part in the scan.
- R7: An address hits a range when (addr & mask) equals (base & mask), with bits 11:0 of both ignored. The range's type is bits 7:0 of its base. A single hit returns that type, and no hit returns the default type.
- R8: End is exclusive: end-1 is the address compared. If start and end-1 disagree on hitting any enabled range visited, the result is 0xFE.
- R9: Types are coded uncacheable=0, write-combining=1, write-through=4, write-protect=5, write-back=6. Two hits merge as follows: uncacheable with anything gives 0, write-back with write-through gives 4, two other unequal types give 0, and equal types keep that type.
- R10: A merge that yields uncacheable ends the scan at once, so a later range that would cause 0xFE is not reached.
- R11: After a full scan, a nonzero upper limit with start ≥ 2^32 and end-1 < limit returns 6, whatever ranges hit.
- R12: `done` is a one-cycle pulse that comes at most NUM_VAR+2 cycles after acceptance. `req_ready` is 0 from acceptance until `done`.
- R13: With the fixed-table flag clear, addresses below 0x100000 go to the variable-range path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fix_we | input | 1 | Write one fixed-table entry |
| fix_idx | input | 7 | Fixed-table entry index (0..87) |
| fix_type | input | 8 | Fixed-table entry type |
| var_we | input | 1 | Write one variable range |
| var_idx | input | $clog2(NUM_VAR) | Variable range number |
| var_base | input | ADDR_W | Range base; bits 7:0 hold the type |
| var_mask | input | ADDR_W | Range mask; bit 11 enables the range |
| ctl_we | input | 1 | Write the control word |
| ctl_def_type | input | 8 | Default type |
| ctl_enable | input | 2 | Bit 0 fixed enable, bit 1 variable-range enable |
| ctl_has_fixed | input | 1 | Fixed table present |
| ctl_upper_limit | input | ADDR_W | Upper write-back limit, 0 = off |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken |
| req_start | input | ADDR_W | First byte of range |
| req_end | input | ADDR_W | Exclusive end of range |
| done | output | 1 | Result valid pulse |
| result | output | 8 | Type or error code |

## Verification
The hardest case to reach is R10. An uncacheable merge has to end the scan before a later range whose boundary splits the request. Only then does the early stop show up as 0 rather than 0xFE. The stimulus stacks a 16 MiB uncacheable range, an overlapping 1 MiB write-back range, and a 4 KiB range at the same base, in rising index order. It then asks for an 8 KiB span that the 4 KiB range cuts. The same bank also sets up a write-back/write-through pair under the upper limit, so one setup reaches both R9 and R11.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

  typedef logic [7:0] mem_type_t;

  localparam mem_type_t MT_UC      = 8'd0;
  localparam mem_type_t MT_WC      = 8'd1;
  localparam mem_type_t MT_WT      = 8'd4;
  localparam mem_type_t MT_WP      = 8'd5;
  localparam mem_type_t MT_WB      = 8'd6;
  localparam mem_type_t MT_OFF     = 8'hFF;
  localparam mem_type_t MT_PARTIAL = 8'hFE;

  localparam int FIX_ENTRIES = 88;
  localparam int FIX_IDX_W   = 7;

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_SCAN} scan_state_t;

  typedef struct packed {
    logic      stop;
    mem_type_t typ;
  } merge_t;

  // Table slot for an address below 1 MiB: 64K, 16K and 4K granule bands
  function automatic logic [FIX_IDX_W-1:0] fixed_slot(input logic [19:0] a);
    logic [19:0] off;
    if (a < 20'h80000) begin
      off = a >> 16;
      return FIX_IDX_W'(off);
    end else if (a < 20'hC0000) begin
      off = (a - 20'h80000) >> 14;
      return FIX_IDX_W'(8) + FIX_IDX_W'(off);
    end else begin
      off = (a - 20'hC0000) >> 12;
      return FIX_IDX_W'(24) + FIX_IDX_W'(off);
    end
  endfunction

  // Precedence merge of an accumulated type with a new hit
  function automatic merge_t merge_types(input mem_type_t acc, input mem_type_t cur);
    merge_t m;
    if (acc == MT_UC || cur == MT_UC) begin
      m.stop = 1'b1; m.typ = MT_UC;
    end else if ((acc == MT_WB && cur == MT_WT) || (acc == MT_WT && cur == MT_WB)) begin
      m.stop = 1'b0; m.typ = MT_WT;
    end else if (acc != cur) begin
      m.stop = 1'b1; m.typ = MT_UC;
    end else begin
      m.stop = 1'b0; m.typ = acc;
    end
    return m;
  endfunction

endpackage

// File: rtl/mtr_fixed_table.sv
module mtr_fixed_table
  import mtr_pkg::*;
#(
  parameter int ENTRIES = FIX_ENTRIES,
  parameter int IDX_W   = FIX_IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  mem_type_t        wdata,
  input  logic [IDX_W-1:0] ridx,
  output mem_type_t        rdata
);

  mem_type_t slot_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[g] <= MT_UC;
      else if (we && widx == IDX_W'(g))
        slot_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = MT_UC;
    if (32'(ridx) < ENTRIES)
      rdata = slot_q[ridx];
  end

endmodule

// File: rtl/mtr_var_bank.sv
module mtr_var_bank
  import mtr_pkg::*;
#(
  parameter int NUM_VAR = 8,
  parameter int ADDR_W  = 40,
  parameter int IDX_W   = $clog2(NUM_VAR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [ADDR_W-1:0] wbase,
  input  logic [ADDR_W-1:0] wmask,
  input  logic [IDX_W-1:0]  sel,
  input  logic [ADDR_W-1:0] a_first,
  input  logic [ADDR_W-1:0] a_last,
  output logic              sel_on,
  output logic              first_hit,
  output logic              last_hit,
  output mem_type_t         sel_type
);

  localparam int ON_BIT = 11;

  logic [ADDR_W-1:0] base_q [NUM_VAR];
  logic [ADDR_W-1:0] mask_q [NUM_VAR];

  function automatic logic in_range(input logic [ADDR_W-1:0] addr,
                                    input logic [ADDR_W-1:0] base,
                                    input logic [ADDR_W-1:0] mask);
    logic [ADDR_W-1:0] m;
    m = mask;
    m[11:0] = '0;
    return ((addr ^ base) & m) == '0;
  endfunction

  for (genvar g = 0; g < NUM_VAR; g++) begin : g_rng
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g] <= '0;
        mask_q[g] <= '0;
      end else if (we && widx == IDX_W'(g)) begin
        base_q[g] <= wbase;
        mask_q[g] <= wmask;
      end
    end
  end

  logic [ADDR_W-1:0] cur_base, cur_mask;

  always_comb begin
    cur_base = '0;
    cur_mask = '0;
    if (32'(sel) < NUM_VAR) begin
      cur_base = base_q[sel];
      cur_mask = mask_q[sel];
    end
  end

  assign sel_on    = cur_mask[ON_BIT];
  assign sel_type  = cur_base[7:0];
  assign first_hit = in_range(a_first, cur_base, cur_mask);
  assign last_hit  = in_range(a_last,  cur_base, cur_mask);

endmodule

// File: rtl/mtr_scan_step.sv
module mtr_scan_step
  import mtr_pkg::*;
(
  input  logic      sel_on,
  input  logic      first_hit,
  input  logic      last_hit,
  input  mem_type_t sel_type,
  input  logic      have,
  input  mem_type_t acc,
  output logic      err,
  output logic      stop,
  output mem_type_t stop_type,
  output logic      nxt_have,
  output mem_type_t nxt_acc
);

  logic   hit;
  merge_t mg;

  assign err       = sel_on && (first_hit != last_hit);
  assign hit       = sel_on && first_hit && last_hit;
  assign mg        = merge_types(acc, sel_type);
  assign stop      = hit && have && mg.stop;
  assign stop_type = mg.typ;
  assign nxt_have  = have | hit;
  assign nxt_acc   = !hit ? acc : (!have ? sel_type : mg.typ);

endmodule

// File: rtl/mem_type_resolver.sv
module mem_type_resolver
  import mtr_pkg::*;
#(
  parameter int NUM_VAR = 8,
  parameter int ADDR_W  = 40,
  localparam int IDX_W  = $clog2(NUM_VAR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fix_we,
  input  logic [6:0]        fix_idx,
  input  logic [7:0]        fix_type,
  input  logic              var_we,
  input  logic [IDX_W-1:0]  var_idx,
  input  logic [ADDR_W-1:0] var_base,
  input  logic [ADDR_W-1:0] var_mask,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_def_type,
  input  logic [1:0]        ctl_enable,
  input  logic              ctl_has_fixed,
  input  logic [ADDR_W-1:0] ctl_upper_limit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_start,
  input  logic [ADDR_W-1:0] req_end,
  output logic              done,
  output logic [7:0]        result
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_VAR - 1);

  scan_state_t       state_q;
  logic [ADDR_W-1:0] first_q, last_q, lim_q;
  logic [IDX_W-1:0]  idx_q;
  logic              have_q, done_q, cfg_q, hasfix_q;
  logic [1:0]        en_q;
  mem_type_t         acc_q, res_q, def_q;

  // Named events for the checker
  logic accept_w, pre_off_w, scan_err_w, override_w;
  logic cfg_off, fixed_sel, var_off, up_cond, at_last;

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= 1'b0;
      def_q    <= MT_UC;
      en_q     <= '0;
      hasfix_q <= 1'b0;
      lim_q    <= '0;
    end else if (ctl_we) begin
      cfg_q    <= 1'b1;
      def_q    <= ctl_def_type;
      en_q     <= ctl_enable;
      hasfix_q <= ctl_has_fixed;
      lim_q    <= ctl_upper_limit;
    end
  end

  mem_type_t fix_rd;

  mtr_fixed_table #(.ENTRIES(FIX_ENTRIES), .IDX_W(FIX_IDX_W)) u_fix (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (fix_we),
    .widx  (fix_idx),
    .wdata (fix_type),
    .ridx  (fixed_slot(first_q[19:0])),
    .rdata (fix_rd)
  );

  logic      sel_on, first_hit, last_hit;
  mem_type_t sel_type;

  mtr_var_bank #(.NUM_VAR(NUM_VAR), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (var_we),
    .widx      (var_idx),
    .wbase     (var_base),
    .wmask     (var_mask),
    .sel       (idx_q),
    .a_first   (first_q),
    .a_last    (last_q),
    .sel_on    (sel_on),
    .first_hit (first_hit),
    .last_hit  (last_hit),
    .sel_type  (sel_type)
  );

  logic      st_err, st_stop, nxt_have;
  mem_type_t st_type, nxt_acc;

  mtr_scan_step u_step (
    .sel_on    (sel_on),
    .first_hit (first_hit),
    .last_hit  (last_hit),
    .sel_type  (sel_type),
    .have      (have_q),
    .acc       (acc_q),
    .err       (st_err),
    .stop      (st_stop),
    .stop_type (st_type),
    .nxt_have  (nxt_have),
    .nxt_acc   (nxt_acc)
  );

  assign accept_w   = req_valid && (state_q == S_IDLE);
  assign cfg_off    = !cfg_q || (en_q == 2'b00);
  assign fixed_sel  = hasfix_q && !(|first_q[ADDR_W-1:20]);
  assign var_off    = !en_q[1];
  assign up_cond    = (lim_q != '0) && (|first_q[ADDR_W-1:32]) && (last_q < lim_q);
  assign at_last    = (idx_q == LAST_IDX);
  assign pre_off_w  = (state_q == S_PRE) && cfg_off;
  assign scan_err_w = (state_q == S_SCAN) && st_err;
  assign override_w = (state_q == S_SCAN) && !st_err && !st_stop && at_last && up_cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      first_q <= '0;
      last_q  <= '0;
      idx_q   <= '0;
      have_q  <= 1'b0;
      acc_q   <= MT_UC;
      done_q  <= 1'b0;
      res_q   <= MT_UC;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (accept_w) begin
            first_q <= req_start;
            last_q  <= req_end - ADDR_W'(1);
            state_q <= S_PRE;
          end
        end
        S_PRE: begin
          idx_q  <= '0;
          have_q <= 1'b0;
          acc_q  <= MT_UC;
          if (cfg_off || fixed_sel || var_off) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
            res_q   <= cfg_off ? MT_OFF : (fixed_sel ? fix_rd : def_q);
          end else begin
            state_q <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (st_err) begin
            done_q  <= 1'b1;
            res_q   <= MT_PARTIAL;
            state_q <= S_IDLE;
          end else if (st_stop) begin
            done_q  <= 1'b1;
            res_q   <= st_type;
            state_q <= S_IDLE;
          end else if (at_last) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
            res_q   <= up_cond ? MT_WB : (nxt_have ? nxt_acc : def_q);
          end else begin
            idx_q  <= idx_q + IDX_W'(1);
            have_q <= nxt_have;
            acc_q  <= nxt_acc;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == S_IDLE);
  assign done      = done_q;
  assign result    = res_q;

endmodule

// File: rtl/mtr_checker.sv
module mtr_checker #(
  parameter int NUM_VAR = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       done,
  input logic [7:0] result,
  input logic       accept_w,
  input logic       pre_off_w,
  input logic       scan_err_w,
  input logic       override_w
);

  int unsigned busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy_cnt <= 0;
    else if (accept_w)   busy_cnt <= 1;
    else if (!req_ready) busy_cnt <= busy_cnt + 1;
    else                 busy_cnt <= 0;
  end

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  ready_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  // R12
  latency_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (busy_cnt <= NUM_VAR + 1));

  // R3
  off_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_off_w |=> (done && result == 8'hFF));

  // R8
  partial_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_err_w |=> (done && result == 8'hFE));

  // R11
  upper_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    override_w |=> (done && result == 8'd6));

endmodule

bind mem_type_resolver mtr_checker #(.NUM_VAR(NUM_VAR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .done       (done),
  .result     (result),
  .accept_w   (accept_w),
  .pre_off_w  (pre_off_w),
  .scan_err_w (scan_err_w),
  .override_w (override_w)
);

// File: tb/sim_mem_type_resolver.sv
module sim_mem_type_resolver;

  localparam int NV = 8;
  localparam int AW = 40;
  localparam int IW = $clog2(NV);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fix_we = 0, var_we = 0, ctl_we = 0, req_valid = 0, ctl_has_fixed = 0;
  logic [6:0]    fix_idx = '0;
  logic [7:0]    fix_type = '0, ctl_def_type = '0;
  logic [IW-1:0] var_idx = '0;
  logic [AW-1:0] var_base = '0, var_mask = '0, ctl_upper_limit = '0, req_start = '0, req_end = '0;
  logic [1:0]    ctl_enable = '0;
  logic          req_ready, done;
  logic [7:0]    result;

  always #2 clk = ~clk;

  mem_type_resolver #(.NUM_VAR(NV), .ADDR_W(AW)) u0 (.*);

  // Behavioural reference state
  logic [7:0]    m_fix [88];
  logic [AW-1:0] m_base [NV];
  logic [AW-1:0] m_mask [NV];
  logic [7:0]    m_def = 0;
  logic [1:0]    m_en = 0;
  logic          m_hasfix = 0, m_cfg = 0;
  logic [AW-1:0] m_lim = 0;

  int checks = 0, fails = 0;
  bit pending = 0;
  int lat = 0;
  logic [7:0] exp_res;
  string cur_tag;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] model(input logic [AW-1:0] s, input logic [AW-1:0] e);
    logic [AW-1:0] l, m;
    logic [7:0] cur, t;
    bit found, sh, eh;
    int idx;
    if (!m_cfg || m_en == 0) return 8'hFF;
    l = e - 1;
    if (m_hasfix && s < 'h100000) begin
      if (s < 'h80000)      idx = int'(s) / 65536;
      else if (s < 'hC0000) idx = 8 + (int'(s) - 'h80000) / 16384;
      else                  idx = 24 + (int'(s) - 'hC0000) / 4096;
      return m_fix[idx];
    end
    if (!m_en[1]) return m_def;
    found = 0; cur = 0;
    for (int i = 0; i < NV; i++) begin
      if (!m_mask[i][11]) continue;
      m = m_mask[i] & ~(AW'('hFFF));
      sh = (s & m) == (m_base[i] & m);
      eh = (l & m) == (m_base[i] & m);
      if (sh != eh) return 8'hFE;
      if (!sh) continue;
      t = m_base[i][7:0];
      if (!found) begin found = 1; cur = t; continue; end
      if (cur == 0 || t == 0) return 8'd0;
      if ((cur == 6 && t == 4) || (cur == 4 && t == 6)) begin cur = 4; t = 4; end
      if (cur != t) return 8'd0;
    end
    if (m_lim != 0 && s >= 40'h1_0000_0000 && l < m_lim) return 8'd6;
    return found ? cur : m_def;
  endfunction

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      if (pending) begin
        lat++;
        if (done) begin
          check(result == exp_res, cur_tag, result, exp_res);
          check(lat <= NV + 2, "R12 latency", lat, NV + 2);
          pending = 0;
        end else if (req_ready) begin
          check(0, "R12 ready while busy", 1, 0);
        end
      end else if (done) begin
        check(0, "R12 spurious done", 1, 0);
      end
    end
  end

  task automatic set_ctl(input logic [7:0] d, input logic [1:0] en, input bit hf, input logic [AW-1:0] lim);
    @(negedge clk);
    ctl_we = 1; ctl_def_type = d; ctl_enable = en; ctl_has_fixed = hf; ctl_upper_limit = lim;
    @(negedge clk);
    ctl_we = 0;
    m_cfg = 1; m_def = d; m_en = en; m_hasfix = hf; m_lim = lim;
  endtask

  task automatic set_var(input int i, input logic [AW-1:0] base, input logic [AW-1:0] size,
                         input logic [7:0] typ, input bit on);
    logic [AW-1:0] b, mk;
    b  = (base & ~(AW'('hFFF))) | AW'(typ);
    mk = ~(size - 1) & ~(AW'('hFFF));
    if (on) mk[11] = 1'b1;
    @(negedge clk);
    var_we = 1; var_idx = IW'(i); var_base = b; var_mask = mk;
    @(negedge clk);
    var_we = 0;
    m_base[i] = b; m_mask[i] = mk;
  endtask

  task automatic request(input logic [AW-1:0] s, input logic [AW-1:0] e, input string tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_start = s; req_end = e;
    exp_res = model(s, e);
    cur_tag = tag;
    @(posedge clk);
    #1;
    req_valid = 0;
    pending = 1; lat = 0;
    for (int k = 0; k < NV + 6 && pending; k++) begin
      @(posedge clk); #1;
    end
    if (pending) begin
      check(0, {tag, " no done"}, 0, 1);
      pending = 0;
    end
  endtask

  initial begin
    for (int i = 0; i < 88; i++) m_fix[i] = 0;
    for (int i = 0; i < NV; i++) begin m_base[i] = 0; m_mask[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check(done == 1'b0, "R1 done", done, 0);

    // R2: never configured
    request(40'h1000, 40'h2000, "R2 unconfigured");

    // Fill the fixed table
    for (int i = 0; i < 88; i++) begin
      @(negedge clk);
      fix_we = 1; fix_idx = 7'(i); fix_type = 8'((i * 3 + 1) & 8'hFF);
      m_fix[i] = 8'((i * 3 + 1) & 8'hFF);
    end
    @(negedge clk); fix_we = 0;

    // Variable ranges
    set_var(0, 40'h1_0000_0000, 40'h1000_0000, 8'd6, 1);
    set_var(1, 40'h1_0000_0000, 40'h0400_0000, 8'd4, 1);
    set_var(2, 40'h0_2000_0000, 40'h0010_0000, 8'd1, 1);
    set_var(3, 40'h0_2000_0000, 40'h0010_0000, 8'd5, 1);
    set_var(4, 40'h0_4000_0000, 40'h0100_0000, 8'd0, 1);
    set_var(5, 40'h0_4000_0000, 40'h0010_0000, 8'd6, 1);
    set_var(6, 40'h0_4000_0000, 40'h0000_1000, 8'd6, 1);
    set_var(7, 40'h0_3000_0000, 40'h0020_0000, 8'd6, 0);

    // R3: configured but both enables clear
    set_ctl(8'd1, 2'b00, 1, 0);
    request(40'h2000_0000, 40'h2000_1000, "R3 enables clear");

    // R4: fixed table bands and borders
    set_ctl(8'd1, 2'b11, 1, 0);
    request(40'h00000, 40'h00010, "R4 first 64K");
    request(40'h12345, 40'h9000_0000, "R4 64K end ignored");
    request(40'h7FFFF, 40'h80000, "R4 last 64K");
    request(40'h80000, 40'h81000, "R4 first 16K");
    request(40'hBFFFF, 40'hC0000, "R4 last 16K");
    request(40'hC0000, 40'hC1000, "R4 first 4K");
    request(40'hFFFFF, 40'h100000, "R4 last 4K");

    // R7 single hit, low bits ignored; R8 exclusive end; no hit -> default
    request(40'h1_0800_0000, 40'h1_0800_1000, "R7 single hit");
    request(40'h1_0F00_0000, 40'h1_1000_0000, "R8 exclusive end");
    request(40'h0_5000_0000, 40'h0_5000_1000, "R7 no hit default");
    // R8 partial
    request(40'h1_0FFF_F000, 40'h1_1000_1000, "R8 partial");
    // R9 merges
    request(40'h1_0000_0000, 40'h1_0000_1000, "R9 wb+wt");
    request(40'h0_2000_0000, 40'h0_2000_1000, "R9 wc+wp");
    // R10 early stop on uncacheable
    request(40'h0_4000_0000, 40'h0_4000_2000, "R10 uc stop");
    // R6 disabled range
    request(40'h0_3000_0000, 40'h0_3000_1000, "R6 disabled range");

    // R5 variable ranges off
    set_ctl(8'd5, 2'b01, 1, 0);
    request(40'h1_0800_0000, 40'h1_0800_1000, "R5 var off");

    // R11 upper limit
    set_ctl(8'd1, 2'b11, 1, 40'h2_0000_0000);
    request(40'h1_8000_0000, 40'h1_8000_1000, "R11 no hit wb");
    request(40'h1_0000_0000, 40'h1_0000_1000, "R11 overrides merge");
    request(40'h1_F000_0000, 40'h2_0000_1000, "R11 end past limit");
    request(40'h0_5000_0000, 40'h0_5000_1000, "R11 below 4G");

    // R13 no fixed table
    set_ctl(8'd1, 2'b11, 0, 0);
    request(40'h12345, 40'h13000, "R13 no fixed table");

    repeat (4) @(negedge clk);
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule